// File: doc/BRIEF.md
# Triple 12-bit reload timer unit

This block holds three independent up-counting timers (A, B, C) of equal width. Each timer has a preload value, a compare value and a count-source selector, all loaded through one write port. When a counter steps past its all-ones value it takes the preload value again and emits a single-cycle overflow pulse. When the value it steps to equals the compare value it emits a single-cycle match pulse.

The count source of each timer is set on its own. It can be stopped, the CPU clock-enable tick, rising edges of an external clock pin, or the CPU tick gated by the external pin's level. Timer A also has an input-capture channel. A rising edge on the capture pin stores the counter value and raises a sticky flag, which software clears by writing a one.

The overflow pulses of timers A and B are brought out again as sample-rate ticks for two downstream audio channels. Each timer drives one maskable and one non-maskable interrupt request.

Top module: `triple_timer`

## Requirements
- R1: After reset every output is zero, every preload and compare value is zero, and every timer is stopped.
- R2: Writing register 0 of a timer (address = timer index * 4 + 0) loads both its preload value and its counter with wr_data. No overflow or match pulse comes from that timer in that cycle, even when a count tick coincides.
- R3: Register 2 of a timer (address = index * 4 + 2) selects the count source in wr_data[1:0]: 0 stops the counter, 1 counts on each cycle cpu_tick is high, 2 counts on each synchronized rising edge of ext_clk, and 3 counts on cycles where cpu_tick is high and the synchronized ext_clk level is high. A new selection applies from the cycle after the write.
- R4: A count tick while the counter holds 0xFFF loads the preload value and gives a one-cycle pulse on that timer's ovf bit. audio_tick[0] follows ovf[0] and audio_tick[1] follows ovf[1].
- R5: Register 1 (address = index * 4 + 1) holds the compare value. A one-cycle cmp_hit pulse follows any count tick whose resulting value, including a reloaded value, equals the compare value held before that cycle.
- R6: ext_clk and cap_in each pass through a two-flop synchronizer. A level sampled at clock edge k can first affect counting or capture at edge k+2.
- R7: On a synchronized rising edge of cap_in, cap_val takes timer A's counter value from before that edge's count, and cap_flag is set.
- R8: Writing wr_data[0]=1 to address 3 clears cap_flag. Writing 0 leaves it unchanged, and a capture in the same cycle wins over the clear.
- R9: For each timer, irq is high while ovf or cmp_hit is high, and nmi follows ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | CPU clock-enable tick |
| ext_clk | input | 1 | External clock pin, asynchronous |
| cap_in | input | 1 | Capture pin for timer A, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | {timer index, register index} |
| wr_data | input | 12 | Write data |
| ovf | output | 3 | Per-timer overflow pulses |
| cmp_hit | output | 3 | Per-timer compare-match pulses |
| irq | output | 3 | Per-timer maskable requests |
| nmi | output | 3 | Per-timer non-maskable requests |
| audio_tick | output | 2 | Sample ticks from timers A and B |
| cap_val | output | 12 | Timer A capture value |
| cap_flag | output | 1 | Timer A capture flag |

## Verification
The counters are not visible directly, so a wrong count or a wrong reload value shows up as an overflow or match pulse in the wrong cycle. The pulse moves by up to one full wrap period, and a capture value read in the same cycle exposes the error at once. A synchronizer stage too many or too few moves every external-clock and capture event by one cycle, so the bench's per-cycle model reports it at the first such event. A missing clear or set of the capture flag is seen in the cycle after the write or the pin edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SRC_STOP  = 2'd0,
      SRC_CPU   = 2'd1,
      SRC_EXT   = 2'd2,
      SRC_GATED = 2'd3
   } tmr_src_e;

   localparam logic [1:0] REG_PRELOAD = 2'd0;
   localparam logic [1:0] REG_COMPARE = 2'd1;
   localparam logic [1:0] REG_CONTROL = 2'd2;
   localparam logic [1:0] REG_FLAGCLR = 2'd3;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("tmr_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], din};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign lvl  = sync_q[STAGES-1];
   assign rise = sync_q[STAGES-1] & ~prev_q;

   // R6: an edge indication lasts one cycle only
   a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter bit HAS_CAP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_tick,
   input  logic             ext_lvl,
   input  logic             ext_rise,
   input  logic             cap_rise,
   input  logic             wr_pre,
   input  logic             wr_cmp,
   input  logic             wr_ctl,
   input  logic             wr_clr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             ovf,
   output logic             cmp_hit,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_flag
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, pre_q, cmp_q, nxt;
   tmr_src_e         src_q;
   logic             tick, at_max;

   always_comb begin
      unique case (src_q)
         SRC_CPU:   tick = cpu_tick;
         SRC_EXT:   tick = ext_rise;
         SRC_GATED: tick = cpu_tick & ext_lvl;
         default:   tick = 1'b0;
      endcase
   end

   assign at_max = (cnt_q == MAXV);
   assign nxt    = at_max ? pre_q : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pre_q   <= '0;
         ovf     <= 1'b0;
         cmp_hit <= 1'b0;
      end else if (wr_pre) begin
         pre_q   <= wr_data;
         cnt_q   <= wr_data;
         ovf     <= 1'b0;
         cmp_hit <= 1'b0;
      end else if (tick) begin
         cnt_q   <= nxt;
         ovf     <= at_max;
         cmp_hit <= (nxt == cmp_q);
      end else begin
         ovf     <= 1'b0;
         cmp_hit <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         src_q <= SRC_STOP;
      end else begin
         if (wr_cmp) cmp_q <= wr_data;
         if (wr_ctl) src_q <= tmr_src_e'(wr_data[1:0]);
      end
   end

   generate
      if (HAS_CAP) begin : g_cap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cap_val  <= '0;
               cap_flag <= 1'b0;
            end else if (cap_rise) begin
               cap_val  <= cnt_q;
               cap_flag <= 1'b1;
            end else if (wr_clr && wr_data[0]) begin
               cap_flag <= 1'b0;
            end
         end

         // R7: capture stores the pre-edge count and raises the flag
         a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
            cap_rise |=> (cap_flag && cap_val == $past(cnt_q)));
         // R8: clearing write without a coincident capture drops the flag
         a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_clr && wr_data[0] && !cap_rise) |=> !cap_flag);
      end else begin : g_nocap
         logic unused_cap;
         assign unused_cap = cap_rise ^ wr_clr;
         assign cap_val    = '0;
         assign cap_flag   = 1'b0;
      end
   endgenerate

   // R2: preload write sets the counter and suppresses pulses
   a_r2_preload: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pre |=> (cnt_q == $past(wr_data) && !ovf && !cmp_hit));
   // R3: a stopped timer holds its count
   a_r3_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == SRC_STOP && !wr_pre) |=> ($stable(cnt_q) && !ovf));
   // R4: wrap reloads from preload with an overflow pulse
   a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_max && !wr_pre) |=> (ovf && cnt_q == $past(pre_q)));
   // R4: overflow only follows an all-ones count
   a_r4_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> ($past(cnt_q) == MAXV));
   // R5: a match pulse means the counter equals the old compare value
   a_r5_cmp_value: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit |-> (cnt_q == $past(cmp_q)));
endmodule

// File: rtl/triple_timer.sv
module triple_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int N_TMR       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int TSEL_W     = (N_TMR > 2) ? 2 : 1,
   localparam int ADDR_W     = TSEL_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_tick,
   input  logic              ext_clk,
   input  logic              cap_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [N_TMR-1:0]  ovf,
   output logic [N_TMR-1:0]  cmp_hit,
   output logic [N_TMR-1:0]  irq,
   output logic [N_TMR-1:0]  nmi,
   output logic [1:0]        audio_tick,
   output logic [CNT_W-1:0]  cap_val,
   output logic              cap_flag
);
   generate
      if (N_TMR < 2 || N_TMR > 4) begin : g_bad_n
         $error("triple_timer: N_TMR must be 2..4");
      end
      if (CNT_W < 2) begin : g_bad_w
         $error("triple_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic ext_lvl, ext_rise, cap_lvl, cap_rise;
   logic unused_cap_lvl;
   assign unused_cap_lvl = cap_lvl;

   tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_clk), .lvl(ext_lvl), .rise(ext_rise));
   tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_in), .lvl(cap_lvl), .rise(cap_rise));

   logic [TSEL_W-1:0] w_tmr;
   logic [1:0]        w_reg;
   assign w_tmr = wr_addr[ADDR_W-1:2];
   assign w_reg = wr_addr[1:0];

   logic [N_TMR-1:0][CNT_W-1:0] cap_v;
   logic [N_TMR-1:0]            cap_f;

   genvar g;
   generate
      for (g = 0; g < N_TMR; g++) begin : g_tmr
         logic hit_sel;
         assign hit_sel = wr_en && (w_tmr == TSEL_W'(g));
         tmr_chan #(.CNT_W(CNT_W), .HAS_CAP(g == 0)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cpu_tick (cpu_tick),
            .ext_lvl  (ext_lvl),
            .ext_rise (ext_rise),
            .cap_rise (cap_rise),
            .wr_pre   (hit_sel && w_reg == REG_PRELOAD),
            .wr_cmp   (hit_sel && w_reg == REG_COMPARE),
            .wr_ctl   (hit_sel && w_reg == REG_CONTROL),
            .wr_clr   (hit_sel && w_reg == REG_FLAGCLR),
            .wr_data  (wr_data),
            .ovf      (ovf[g]),
            .cmp_hit  (cmp_hit[g]),
            .cap_val  (cap_v[g]),
            .cap_flag (cap_f[g])
         );
      end
   endgenerate

   logic unused_rest;
   assign unused_rest = ^{cap_v[N_TMR-1:1], cap_f[N_TMR-1:1]};

   assign cap_val    = cap_v[0];
   assign cap_flag   = cap_f[0];
   assign irq        = ovf | cmp_hit;
   assign nmi        = ovf;
   assign audio_tick = ovf[1:0];

   // R7: the flag only rises after a synchronized capture edge
   a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_flag) |-> $past(cap_rise));
endmodule

// File: tb/sim_triple_timer.sv
module sim_triple_timer;
   localparam int CLK_PERIOD = 10;
   localparam int NT   = 3;
   localparam int MAXV = 4095;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cpu_tick = 1'b0, ext_clk = 1'b0, cap_in = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [11:0] wr_data = '0;
   logic [2:0]  ovf, cmp_hit, irq, nmi;
   logic [1:0]  audio_tick;
   logic [11:0] cap_val;
   logic        cap_flag;

   triple_timer u0 (
      .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .ext_clk(ext_clk),
      .cap_in(cap_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ovf(ovf), .cmp_hit(cmp_hit), .irq(irq), .nmi(nmi),
      .audio_tick(audio_tick), .cap_val(cap_val), .cap_flag(cap_flag));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   int m_cnt[NT], m_pre[NT], m_cmp[NT], m_src[NT];
   bit m_ovf[NT], m_hit[NT];
   int m_capv;
   bit m_flag;
   bit e1, e2, e3, c1, c2, c3;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int t = 0; t < NT; t++) begin
            m_cnt[t] = 0; m_pre[t] = 0; m_cmp[t] = 0; m_src[t] = 0;
            m_ovf[t] = 0; m_hit[t] = 0;
         end
         m_capv = 0; m_flag = 0;
         e1 = 0; e2 = 0; e3 = 0; c1 = 0; c2 = 0; c3 = 0;
      end else begin
         bit re, el, rc, tk;
         int old_a, nx, wt, wrg, d;
         re = e2 & ~e3; el = e2; rc = c2 & ~c3;
         e3 = e2; e2 = e1; e1 = ext_clk;
         c3 = c2; c2 = c1; c1 = cap_in;
         wt = int'(wr_addr[3:2]); wrg = int'(wr_addr[1:0]); d = int'(wr_data);
         old_a = m_cnt[0];
         for (int t = 0; t < NT; t++) begin
            case (m_src[t])
               1: tk = cpu_tick;
               2: tk = re;
               3: tk = cpu_tick & el;
               default: tk = 0;
            endcase
            if (wr_en && wt == t && wrg == 0) begin
               m_pre[t] = d; m_cnt[t] = d; m_ovf[t] = 0; m_hit[t] = 0;
            end else if (tk) begin
               m_ovf[t] = (m_cnt[t] == MAXV);
               nx = m_ovf[t] ? m_pre[t] : m_cnt[t] + 1;
               m_hit[t] = (nx == m_cmp[t]);
               m_cnt[t] = nx;
            end else begin
               m_ovf[t] = 0; m_hit[t] = 0;
            end
            if (wr_en && wt == t && wrg == 1) m_cmp[t] = d;
            if (wr_en && wt == t && wrg == 2) m_src[t] = d % 4;
         end
         if (rc) begin
            m_capv = old_a; m_flag = 1;
         end else if (wr_en && wt == 0 && wrg == 3 && wr_data[0]) begin
            m_flag = 0;
         end
      end
   end

   // Per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int eo, eh;
         eo = {29'd0, m_ovf[2], m_ovf[1], m_ovf[0]};
         eh = {29'd0, m_hit[2], m_hit[1], m_hit[0]};
         chk("R2 R3 R4 R6 ovf", int'(ovf), eo);
         chk("R5 cmp_hit", int'(cmp_hit), eh);
         chk("R4 audio_tick", int'(audio_tick), eo % 4);
         chk("R9 irq", int'(irq), eo | eh);
         chk("R9 nmi", int'(nmi), eo);
         chk("R7 cap_val", int'(cap_val), m_capv);
         chk("R8 cap_flag", int'(cap_flag), int'(m_flag));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 12'(d);
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic run(input int n, input int wr_odds);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         cpu_tick = ($urandom % 4) != 0;
         if ($urandom % 3 == 0) ext_clk = ~ext_clk;
         if ($urandom % 9 == 0) cap_in = ~cap_in;
         wr_en = 1'b0;
         if (wr_odds > 0 && $urandom % wr_odds == 0) begin
            wr_en   = 1'b1;
            wr_addr = 4'($urandom);
            wr_data = 12'(4000 + $urandom % 96);
         end
      end
      @(negedge clk); #1; wr_en = 1'b0;
   endtask

   initial begin
      void'($urandom(7));
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      chk("R1 reset ovf", int'(ovf), 0);
      chk("R1 reset cmp_hit", int'(cmp_hit), 0);
      chk("R1 reset irq/nmi", int'({irq, nmi}), 0);
      chk("R1 reset cap", int'({cap_flag, cap_val}), 0);
      #1 rst_n = 1'b1;
      run(20, 0);                       // R1: stopped timers give no pulses
      wr(0, 12'hFF0); wr(1, 12'hFF8); wr(2, 1);   // A: CPU ticks
      wr(4, 12'hFFA); wr(5, 12'hFFC); wr(6, 2);   // B: external edges
      wr(8, 12'hFFD); wr(9, 12'hFFD); wr(10, 3);  // C: gated, match after reload
      run(1500, 0);
      wr(3, 0);                         // R8: writing 0 keeps the flag
      run(5, 0);
      wr(3, 1);                         // R8: clear
      run(5, 0);
      wr(2, 0);                         // R3: stop A, captures hold one value
      wr(8, 12'hFFF);                   // C preload all-ones
      run(300, 0);
      wr(2, 1);
      run(1500, 0);
      run(2000, 12);                    // random register traffic
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 100000 && !done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule